// File: doc/BRIEF.md
# Trap and Stack Sequencer

This block owns the status byte, the stack pointer and the program counter hand-off of an 8-bit processor whenever control passes through the stack. It is given the current program counter, an operation strobe with a 3-bit code, and two pending-request levels: a maskable request and a non-maskable one. It then performs the pushes or pulls on the fixed stack page, through a synchronous byte-wide memory port. When the sequence ends, it presents the new program counter, stack pointer and status byte. A one-cycle done pulse marks the end of the sequence, and a cycle-cost value is reported with it.

The entry paths are the software break, the maskable request and the non-maskable request. Each pushes a return address and the status byte, sets the interrupt-disable bit and fetches a vector. The return paths restore either the status byte and the return address, or the return address alone plus one. Two single-byte operations save and restore the status byte. After reset, the block reads the start address from the reset vector before it accepts any work.

Top module: `trap_stack_ctrl`

## Requirements
- R1: Reset sets status to 0x34 and the stack pointer to 0xFF, then reads 0xFFFC (low) and 0xFFFD (high) into the program counter. `busy` is high during that fetch and no done pulse is produced for it.
- R2: Every push writes at address {0x01, SP} and lowers SP by one, modulo 256. A two-byte push writes the high byte first and the low byte next, at the slot below.
- R3: Every pull raises SP by one, modulo 256, and then reads at {0x01, SP}. A two-byte pull reads the low byte first and the high byte from the slot above.
- R4: A break pushes PC+2 and then the status byte with bit 4 set. Afterwards the status byte has bits 4 and 2 set, and PC is loaded from 0xFFFE/0xFFFF.
- R5: The maskable request is taken only while status bit 2 is 0, and a held request has no effect while that bit is 1. Its entry pushes PC and the status byte with bit 4 clear. Afterwards bit 4 is clear and bit 2 is set, PC is loaded from 0xFFFE/0xFFFF, and `irq_ack` pulses together with done.
- R6: The non-maskable request is taken whatever the value of status bit 2. Its entry pushes PC and the status byte with bit 4 clear, sets bit 2, clears bit 4, loads PC from 0xFFFA/0xFFFB, and pulses `nmi_ack` together with done.
- R7: When the block is idle, an enabled maskable request wins over a non-maskable request, and the non-maskable request wins over a start strobe. A strobe that loses is dropped.
- R8: Operation code 1 pushes the status byte with bit 4 forced to 1 and leaves the status register unchanged. Operation code 2 pulls the status byte with bit 5 forced to 1.
- R9: Operation code 3 pulls the status byte (bit 5 forced to 1), then the low and high bytes of PC, with no increment.
- R10: Operation code 4 pulls PC and adds one, modulo 65536.
- R11: Operation codes are 0 break, 1 status push, 2 status pull, 3 interrupt return, 4 subroutine return. `done` pulses for one cycle exactly N clock edges after the edge that accepts the request, with `cycles` = N. N is 7 for all three entries, 3 for code 1, 4 for code 2, and 6 for codes 3 and 4.
- R12: A start strobe with a code of 5, 6 or 7 is ignored: no memory access, no state change, no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Operation strobe, sampled when idle |
| op | input | 3 | Operation code |
| irq_pending | input | 1 | Maskable request level |
| nmi_pending | input | 1 | Non-maskable request level |
| pc_in | input | 16 | Current program counter |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_re | output | 1 | Memory read enable; data returns on the next cycle |
| mem_rdata | input | 8 | Memory read data |
| pc_out | output | 16 | Resulting program counter |
| sp_out | output | 8 | Stack pointer |
| p_out | output | 8 | Status byte |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| cycles | output | 4 | Cost of the completed sequence |
| irq_ack | output | 1 | Maskable request serviced |
| nmi_ack | output | 1 | Non-maskable request serviced |

## Verification
The assertions assume that memory returns read data one cycle after `mem_re`. They also assume that a pending level is lowered by its owner once the matching acknowledge pulses, so that a non-maskable request is not serviced twice. The bench holds to both. Its memory model has a one-cycle read latency. It drops each request level in the same cycle that its acknowledge is seen. It changes stack contents only while the block is idle and only between operations.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  typedef enum logic [2:0] {
    K_BRK = 3'd0, K_PHP = 3'd1, K_PLP = 3'd2, K_RTI = 3'd3,
    K_RTS = 3'd4, K_IRQ = 3'd5, K_NMI = 3'd6, K_RST = 3'd7
  } kind_t;

  typedef enum logic [3:0] {
    A_NOP, A_PUSH_PCH, A_PUSH_PCL, A_PUSH_P, A_PULL_P,
    A_PULL_PCL, A_PULL_PCH, A_VEC_LO, A_VEC_HI, A_INC_PC
  } act_t;

  typedef enum logic [1:0] {C_NONE, C_P, C_PCL, C_PCH} cap_t;

  localparam int BIT_I = 2;
  localparam int BIT_B = 4;
  localparam int BIT_R = 5;
  localparam int LAST_SW_OP = 4;

  function automatic int unsigned kind_len(kind_t k);
    case (k)
      K_BRK, K_IRQ, K_NMI: return 7;
      K_PHP:               return 3;
      K_PLP:               return 4;
      K_RTI, K_RTS:        return 6;
      default:             return 3;
    endcase
  endfunction

  // Per-step micro action; reads land one step later (synchronous memory)
  function automatic act_t step_act(kind_t k, int unsigned s);
    act_t a;
    a = A_NOP;
    case (k)
      K_BRK, K_IRQ, K_NMI:
        case (s)
          0: a = A_PUSH_PCH;
          1: a = A_PUSH_PCL;
          2: a = A_PUSH_P;
          3: a = A_VEC_LO;
          4: a = A_VEC_HI;
          default: a = A_NOP;
        endcase
      K_PHP: if (s == 0) a = A_PUSH_P;
      K_PLP: if (s == 1) a = A_PULL_P;
      K_RTI:
        case (s)
          0: a = A_PULL_P;
          1: a = A_PULL_PCL;
          2: a = A_PULL_PCH;
          default: a = A_NOP;
        endcase
      K_RTS:
        case (s)
          0: a = A_PULL_PCL;
          1: a = A_PULL_PCH;
          3: a = A_INC_PC;
          default: a = A_NOP;
        endcase
      K_RST:
        case (s)
          0: a = A_VEC_LO;
          1: a = A_VEC_HI;
          default: a = A_NOP;
        endcase
      default: a = A_NOP;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/tsc_arbiter.sv
module tsc_arbiter
  import tsc_pkg::*;
(
  input  logic       busy,
  input  logic       start,
  input  logic [2:0] op,
  input  logic       irq_pending,
  input  logic       nmi_pending,
  input  logic       i_flag,
  output logic       take,
  output kind_t      kind
);
  always_comb begin
    take = 1'b0;
    kind = K_BRK;
    if (!busy) begin
      if (irq_pending && !i_flag) begin
        take = 1'b1;
        kind = K_IRQ;
      end else if (nmi_pending) begin
        take = 1'b1;
        kind = K_NMI;
      end else if (start && (int'(op) <= LAST_SW_OP)) begin
        take = 1'b1;
        kind = kind_t'(op);
      end
    end
  end
endmodule

// File: rtl/tsc_stepper.sv
module tsc_stepper
  import tsc_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  kind_t            kind_in,
  output logic             busy,
  output kind_t            kind,
  output logic [IDX_W-1:0] idx,
  output logic             fin,
  output act_t             act
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b1;
      kind <= K_RST;
      idx  <= '0;
    end else if (!busy) begin
      if (take) begin
        busy <= 1'b1;
        kind <= kind_in;
        idx  <= '0;
      end
    end else if (fin) begin
      busy <= 1'b0;
    end else begin
      idx <= idx + 1'b1;
    end
  end

  always_comb begin
    fin = busy && (idx == IDX_W'(kind_len(kind) - 1));
    act = busy ? step_act(kind, int'(idx)) : A_NOP;
  end
endmodule

// File: rtl/tsc_stack_port.sv
module tsc_stack_port
  import tsc_pkg::*;
#(
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] VEC_NMI    = 16'hFFFA,
  parameter logic [15:0] VEC_RST    = 16'hFFFC,
  parameter logic [15:0] VEC_IRQ    = 16'hFFFE
) (
  input  act_t        act,
  input  kind_t       kind,
  input  logic [7:0]  sp,
  input  logic [15:0] pc,
  input  logic [7:0]  p,
  output logic [15:0] addr,
  output logic        we,
  output logic [7:0]  wdata,
  output logic        re,
  output cap_t        cap
);
  logic [15:0] vec_base;
  logic [7:0]  p_image;
  logic        hw_entry;

  always_comb begin
    case (kind)
      K_NMI:   vec_base = VEC_NMI;
      K_RST:   vec_base = VEC_RST;
      default: vec_base = VEC_IRQ;
    endcase
    hw_entry = (kind == K_IRQ) || (kind == K_NMI);
    p_image  = p;
    p_image[BIT_B] = !hw_entry;
  end

  always_comb begin
    addr  = {STACK_PAGE, sp};
    we    = 1'b0;
    wdata = 8'h00;
    re    = 1'b0;
    cap   = C_NONE;
    case (act)
      A_PUSH_PCH: begin we = 1'b1; wdata = pc[15:8]; end
      A_PUSH_PCL: begin we = 1'b1; wdata = pc[7:0];  end
      A_PUSH_P:   begin we = 1'b1; wdata = p_image;  end
      A_PULL_P:   begin re = 1'b1; addr = {STACK_PAGE, sp + 8'd1}; cap = C_P;   end
      A_PULL_PCL: begin re = 1'b1; addr = {STACK_PAGE, sp + 8'd1}; cap = C_PCL; end
      A_PULL_PCH: begin re = 1'b1; addr = {STACK_PAGE, sp + 8'd1}; cap = C_PCH; end
      A_VEC_LO:   begin re = 1'b1; addr = vec_base;         cap = C_PCL; end
      A_VEC_HI:   begin re = 1'b1; addr = vec_base + 16'd1; cap = C_PCH; end
      default: ;
    endcase
  end
endmodule

// File: rtl/trap_stack_ctrl.sv
module trap_stack_ctrl
  import tsc_pkg::*;
#(
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] VEC_NMI    = 16'hFFFA,
  parameter logic [15:0] VEC_RST    = 16'hFFFC,
  parameter logic [15:0] VEC_IRQ    = 16'hFFFE,
  parameter logic [7:0]  P_RESET    = 8'h34,
  parameter logic [7:0]  SP_RESET   = 8'hFF,
  parameter int          CNT_W      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [2:0]       op,
  input  logic             irq_pending,
  input  logic             nmi_pending,
  input  logic [15:0]      pc_in,
  output logic [15:0]      mem_addr,
  output logic             mem_we,
  output logic [7:0]       mem_wdata,
  output logic             mem_re,
  input  logic [7:0]       mem_rdata,
  output logic [15:0]      pc_out,
  output logic [7:0]       sp_out,
  output logic [7:0]       p_out,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] cycles,
  output logic             irq_ack,
  output logic             nmi_ack
);
  localparam int IDX_W = 3;

  logic             take;
  kind_t            req_kind;
  kind_t            kind;
  logic [IDX_W-1:0] idx;
  logic             fin;
  act_t             act;
  cap_t             cap_now;
  cap_t             cap_q;
  logic [7:0]       sp_q;
  logic [7:0]       p_q;
  logic [15:0]      pc_q;

  tsc_arbiter u_arb (
    .busy(busy), .start(start), .op(op), .irq_pending(irq_pending),
    .nmi_pending(nmi_pending), .i_flag(p_q[BIT_I]), .take(take), .kind(req_kind)
  );

  tsc_stepper #(.IDX_W(IDX_W)) u_step (
    .clk(clk), .rst(rst), .take(take), .kind_in(req_kind), .busy(busy),
    .kind(kind), .idx(idx), .fin(fin), .act(act)
  );

  tsc_stack_port #(
    .STACK_PAGE(STACK_PAGE), .VEC_NMI(VEC_NMI), .VEC_RST(VEC_RST), .VEC_IRQ(VEC_IRQ)
  ) u_port (
    .act(act), .kind(kind), .sp(sp_q), .pc(pc_q), .p(p_q), .addr(mem_addr),
    .we(mem_we), .wdata(mem_wdata), .re(mem_re), .cap(cap_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q    <= SP_RESET;
      p_q     <= P_RESET;
      pc_q    <= '0;
      cap_q   <= C_NONE;
      done    <= 1'b0;
      cycles  <= '0;
      irq_ack <= 1'b0;
      nmi_ack <= 1'b0;
    end else begin
      done    <= 1'b0;
      irq_ack <= 1'b0;
      nmi_ack <= 1'b0;
      cap_q   <= cap_now;

      if (take)
        pc_q <= pc_in + ((req_kind == K_BRK) ? 16'd2 : 16'd0);

      case (act)
        A_PUSH_PCH, A_PUSH_PCL: sp_q <= sp_q - 8'd1;
        A_PUSH_P: begin
          sp_q <= sp_q - 8'd1;
          if (kind != K_PHP) begin
            p_q[BIT_B] <= (kind == K_BRK);
            p_q[BIT_I] <= 1'b1;
          end
        end
        A_PULL_P, A_PULL_PCL, A_PULL_PCH: sp_q <= sp_q + 8'd1;
        A_INC_PC: pc_q <= pc_q + 16'd1;
        default: ;
      endcase

      case (cap_q)
        C_P:     p_q <= mem_rdata | (8'h01 << BIT_R);
        C_PCL:   pc_q[7:0]  <= mem_rdata;
        C_PCH:   pc_q[15:8] <= mem_rdata;
        default: ;
      endcase

      if (fin && (kind != K_RST)) begin
        done    <= 1'b1;
        cycles  <= CNT_W'(kind_len(kind));
        irq_ack <= (kind == K_IRQ);
        nmi_ack <= (kind == K_NMI);
      end
    end
  end

  assign pc_out = pc_q;
  assign sp_out = sp_q;
  assign p_out  = p_q;
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        irq_pending,
  input logic        nmi_pending,
  input logic [15:0] mem_addr,
  input logic        mem_we,
  input logic        mem_re,
  input logic [7:0]  sp_out,
  input logic [7:0]  p_out,
  input logic        busy,
  input logic        done,
  input logic        irq_ack,
  input logic        nmi_ack
);
  // R2
  push_page_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[15:8] == 8'h01) && !mem_re);

  // R2
  push_sp_dec_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (sp_out == $past(sp_out) - 8'd1));

  // R3
  pull_sp_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_re && (mem_addr[15:8] == 8'h01)) |=> (sp_out == $past(sp_out) + 8'd1));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start && !nmi_pending && !(irq_pending && !p_out[2]))
      |=> ($stable(sp_out) && $stable(p_out) && !busy));

  // R5
  irq_ack_mask_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> (p_out[2] && !p_out[4] && done));

  // R6
  nmi_ack_mask_chk: assert property (@(posedge clk) disable iff (rst)
    nmi_ack |-> (p_out[2] && !p_out[4] && done && !irq_ack));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind trap_stack_ctrl tsc_checker u_tsc_chk (
  .clk(clk), .rst(rst), .start(start), .irq_pending(irq_pending),
  .nmi_pending(nmi_pending), .mem_addr(mem_addr), .mem_we(mem_we),
  .mem_re(mem_re), .sp_out(sp_out), .p_out(p_out), .busy(busy),
  .done(done), .irq_ack(irq_ack), .nmi_ack(nmi_ack)
);

// File: tb/sim_trap_stack_ctrl.sv
`timescale 1ns/1ps
module sim_trap_stack_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [2:0]  op;
  logic        irq_pending;
  logic        nmi_pending;
  logic [15:0] pc_in;
  logic [15:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata;
  logic        mem_re;
  logic [7:0]  mem_rdata;
  logic [15:0] pc_out;
  logic [7:0]  sp_out;
  logic [7:0]  p_out;
  logic        busy;
  logic        done;
  logic [3:0]  cycles;
  logic        irq_ack;
  logic        nmi_ack;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  trap_stack_ctrl u0 (
    .clk(clk), .rst(rst), .start(start), .op(op), .irq_pending(irq_pending),
    .nmi_pending(nmi_pending), .pc_in(pc_in), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .pc_out(pc_out), .sp_out(sp_out), .p_out(p_out),
    .busy(busy), .done(done), .cycles(cycles), .irq_ack(irq_ack), .nmi_ack(nmi_ack)
  );

  // Stack page memory plus constant vectors; one-cycle read latency
  logic [7:0] stk [256];
  logic       poke_en = 1'b0;
  logic [7:0] poke_a;
  logic [7:0] poke_d;
  localparam logic [15:0] V_NMI = 16'h9AC3;
  localparam logic [15:0] V_RST = 16'hE000;
  localparam logic [15:0] V_IRQ = 16'h5A71;

  always @(posedge clk) begin
    if (poke_en) stk[poke_a] <= poke_d;
    else if (mem_we && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) begin
      case (mem_addr)
        16'hFFFA: mem_rdata <= V_NMI[7:0];
        16'hFFFB: mem_rdata <= V_NMI[15:8];
        16'hFFFC: mem_rdata <= V_RST[7:0];
        16'hFFFD: mem_rdata <= V_RST[15:8];
        16'hFFFE: mem_rdata <= V_IRQ[7:0];
        16'hFFFF: mem_rdata <= V_IRQ[15:8];
        default:  mem_rdata <= (mem_addr[15:8] == 8'h01) ? stk[mem_addr[7:0]] : 8'h00;
      endcase
    end
  end

  logic [7:0]  e_sp;
  logic [7:0]  e_p;
  logic [15:0] e_pc;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    poke_en = 1'b1; poke_a = a; poke_d = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  // Called at a negedge with request inputs already set; returns edges from accept to done
  task automatic serve(output int lat);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end while (!done && lat < 40);
  endtask

  task automatic run_op(input logic [2:0] code, input logic [15:0] pcv, output int lat);
    start = 1'b1; op = code; pc_in = pcv;
    serve(lat);
  endtask

  // k: 0 break, 1 maskable, 2 non-maskable
  task automatic chk_entry(input string tag, input int k, input logic [15:0] pcv, input int lat);
    logic [15:0] ret;
    logic [7:0]  pp;
    ret = pcv + ((k == 0) ? 16'd2 : 16'd0);
    pp  = (k == 0) ? (e_p | 8'h10) : (e_p & 8'hEF);
    chk({tag, " R2 push hi"}, stk[e_sp], ret[15:8]);
    chk({tag, " R2 push lo"}, stk[e_sp - 8'd1], ret[7:0]);
    chk({tag, " pushed status"}, stk[e_sp - 8'd2], pp);
    e_sp = e_sp - 8'd3;
    e_p  = pp | 8'h04;
    e_pc = (k == 2) ? V_NMI : V_IRQ;
    chk({tag, " sp"}, sp_out, e_sp);
    chk({tag, " status"}, p_out, e_p);
    chk({tag, " pc"}, pc_out, e_pc);
    chk({tag, " R11 latency"}, lat, 7);
    chk({tag, " R11 cycles"}, cycles, 7);
  endtask

  task automatic do_rti(input string tag);
    int lat;
    run_op(3'd3, 16'h0000, lat);
    e_p  = stk[e_sp + 8'd1] | 8'h20;
    e_pc = {stk[e_sp + 8'd3], stk[e_sp + 8'd2]};
    e_sp = e_sp + 8'd3;
    chk({tag, " R9 status"}, p_out, e_p);
    chk({tag, " R9 pc"}, pc_out, e_pc);
    chk({tag, " R3 sp"}, sp_out, e_sp);
    chk({tag, " R11 latency"}, lat, 6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int lat;
    int acks;
    logic [15:0] rv;
    rst = 1'b1; start = 1'b0; op = 3'd0; irq_pending = 1'b0; nmi_pending = 1'b0;
    pc_in = 16'h0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    acks = 0;
    for (int w = 0; w < 20 && busy; w++) begin
      @(negedge clk);
      if (done) acks++;
    end
    // R1
    chk("R1 pc", pc_out, V_RST);
    chk("R1 sp", sp_out, 8'hFF);
    chk("R1 status", p_out, 8'h34);
    chk("R1 busy", busy, 1'b0);
    chk("R1 no done", acks, 0);
    e_sp = 8'hFF; e_p = 8'h34; e_pc = V_RST;

    // R12 reserved codes
    for (int c = 5; c < 8; c++) begin
      start = 1'b1; op = 3'(c);
      @(negedge clk);
      start = 1'b0;
      acks = 0;
      for (int w = 0; w < 8; w++) begin
        @(negedge clk);
        if (done || busy) acks++;
      end
      chk("R12 no activity", acks, 0);
      chk("R12 sp", sp_out, e_sp);
      chk("R12 status", p_out, e_p);
    end

    // R5 masked request has no effect
    irq_pending = 1'b1;
    acks = 0;
    for (int w = 0; w < 10; w++) begin
      @(negedge clk);
      if (busy || irq_ack) acks++;
    end
    irq_pending = 1'b0;
    chk("R5 masked ignored", acks, 0);
    chk("R5 masked sp", sp_out, e_sp);

    // R8 status push
    run_op(3'd1, 16'h0000, lat);
    chk("R8 pushed B set", stk[e_sp], e_p | 8'h10);
    e_sp = e_sp - 8'd1;
    chk("R8 status kept", p_out, e_p);
    chk("R2 sp", sp_out, e_sp);
    chk("R11 push latency", lat, 3);
    chk("R11 push cycles", cycles, 3);

    // R8 status pull over every byte value, SP wraps 0xFF to 0x00 on the way
    for (int v = 0; v < 256; v++) begin
      poke(e_sp + 8'd1, 8'(v));
      run_op(3'd2, 16'h0000, lat);
      e_sp = e_sp + 8'd1;
      e_p  = 8'(v) | 8'h20;
      chk("R8 pulled status", p_out, e_p);
      chk("R3 sp", sp_out, e_sp);
      chk("R11 pull latency", lat, 4);
    end

    // Move SP to 0x01 with clear status
    while (e_sp != 8'h01) begin
      poke(e_sp + 8'd1, 8'h00);
      run_op(3'd2, 16'h0000, lat);
      e_sp = e_sp + 8'd1;
      e_p  = 8'h20;
    end
    chk("R3 sp setup", sp_out, 8'h01);

    // R4 break across the page wrap of the stack
    run_op(3'd0, 16'h12FE, lat);
    chk_entry("R4", 0, 16'h12FE, lat);
    chk("R4 no ack", irq_ack | nmi_ack, 1'b0);
    do_rti("R9 after break");

    // R5 maskable entry
    irq_pending = 1'b1; pc_in = 16'hBEEF;
    serve(lat);
    chk("R5 ack", irq_ack, 1'b1);
    irq_pending = 1'b0;
    chk_entry("R5", 1, 16'hBEEF, lat);

    // R6 non-maskable while masked
    nmi_pending = 1'b1; pc_in = 16'h0042;
    serve(lat);
    chk("R6 ack", nmi_ack, 1'b1);
    chk("R6 other ack", irq_ack, 1'b0);
    nmi_pending = 1'b0;
    chk_entry("R6", 2, 16'h0042, lat);
    do_rti("R9 nested");
    do_rti("R9 outer");

    // R7 maskable wins over non-maskable
    irq_pending = 1'b1; nmi_pending = 1'b1; pc_in = 16'h7777;
    serve(lat);
    chk("R7 first is maskable", irq_ack, 1'b1);
    irq_pending = 1'b0;
    chk_entry("R7 first", 1, 16'h7777, lat);
    serve(lat);
    chk("R7 second is non-maskable", nmi_ack, 1'b1);
    nmi_pending = 1'b0;
    chk_entry("R7 second", 2, 16'h7777, lat);
    do_rti("R9 unwind a");
    do_rti("R9 unwind b");

    // R7 non-maskable wins over a start strobe, which is dropped
    nmi_pending = 1'b1; start = 1'b1; op = 3'd1; pc_in = 16'h0300;
    serve(lat);
    chk("R7 nmi over start", nmi_ack, 1'b1);
    nmi_pending = 1'b0;
    chk_entry("R7 strobe lost", 2, 16'h0300, lat);
    acks = 0;
    for (int w = 0; w < 6; w++) begin
      @(negedge clk);
      if (busy || done) acks++;
    end
    chk("R7 dropped strobe", acks, 0);
    chk("R7 dropped sp", sp_out, e_sp);
    do_rti("R9 after drop");

    // R10 subroutine return, including carries and wrap
    for (int t = 0; t < 4; t++) begin
      case (t)
        0: rv = 16'h1234;
        1: rv = 16'h00FF;
        2: rv = 16'hFFFF;
        default: rv = 16'h7FFF;
      endcase
      poke(e_sp + 8'd1, rv[7:0]);
      poke(e_sp + 8'd2, rv[15:8]);
      run_op(3'd4, 16'h0000, lat);
      e_sp = e_sp + 8'd2;
      e_pc = rv + 16'd1;
      chk("R10 pc", pc_out, e_pc);
      chk("R10 status kept", p_out, e_p);
      chk("R3 sp", sp_out, e_sp);
      chk("R11 return latency", lat, 6);
      chk("R11 return cycles", cycles, 6);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule